// File: doc/BRIEF.md
# PCM Serial Voice Port

This block is the digital framing logic of a single-channel telephony voice port. On the receive side it takes a serial PCM stream clocked by an external bit clock. A short receive sync pulse marks where each frame starts. The block collects eight bits and hands the finished sample to the core as a parallel byte, together with a one-cycle valid strobe. On the transmit side a short transmit sync pulse loads a parallel byte. The block then sends that byte serially, most significant bit first, and asserts an output enable only while its eight bit slots are on the line.

The bit clock, both sync pulses and the serial input are oversampled by a free-running system clock. Because of this, the block does not depend on any ratio between the bit rate and the 8 kHz frame rate. The same system clock times a watchdog on the bit clock. If the bit clock stays at one level for a programmable number of system cycles, the block raises a power-save indication. Both serial paths give up their current frame while that indication is high. Companding, filtering, conversion and analog drive belong to other blocks.

Top module: `pcm_voice_port`

## Requirements
- R1: After a rising edge on `rx_sync_i`, the next eight falling edges of `bclk_i` each sample `rx_sd_i`. The first sampled bit becomes bit 7 (MSB) of `rx_word_o` and the eighth becomes bit 0.
- R2: When the eighth bit is sampled, `rx_word_o` takes the new byte and `rx_valid_o` is high for exactly one `clk` cycle. `rx_word_o` keeps that value until the next complete frame.
- R3: Falling edges of `bclk_i` after the eighth bit of a frame change neither `rx_word_o` nor `rx_valid_o` until the next rising edge of `rx_sync_i`.
- R4: A rising edge of `rx_sync_i` after 1 to 7 bits of a frame throws away the partial byte (no `rx_valid_o` pulse) and starts a new frame at that sync. It also sets `rx_ferr_o`, which stays high until reset.
- R5: A rising edge of `tx_sync_i` loads `tx_word_i`. Each of the next eight rising edges of `bclk_i` puts one bit on `tx_sd_o`, MSB first, with `tx_oe_o` high. The ninth rising edge drives `tx_oe_o` low. A bit-clock rising edge detected in the same cycle as the sync rising edge sends nothing, and `tx_oe_o` is low outside the eight slots.
- R6: `pwr_save_o` goes high once no edge of `bclk_i` has been detected for `stop_limit_i` consecutive `clk` cycles. It goes low again in the cycle after the first new bit-clock edge is detected.
- R7: While `pwr_save_o` is high, both paths drop any frame in progress and `tx_oe_o` is low. Bit-clock edges that arrive later without a fresh sync produce no `rx_valid_o` pulse and no transmit slot.
- R8: Every serial input is sampled by `clk` through a two-stage synchronizer, so a pin edge takes effect three `clk` cycles after it is sampled. Any bit clock whose high and low phases each last at least two `clk` cycles is handled, whatever its ratio to 8 kHz.
- R9: While `rst_n` is low, `rx_word_o` is 0 and `rx_valid_o`, `rx_ferr_o`, `tx_sd_o`, `tx_oe_o` and `pwr_save_o` are low. Reset takes effect asynchronously and is released on the second `clk` edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system and oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock |
| rx_sync_i | input | 1 | Receive frame sync, rising edge marks the MSB |
| rx_sd_i | input | 1 | Serial receive data |
| tx_sync_i | input | 1 | Transmit frame sync, rising edge loads the byte |
| tx_word_i | input | WORD_W | Byte to send in the next transmit frame |
| stop_limit_i | input | STALL_W | Bit-clock stall limit in `clk` cycles |
| rx_word_o | output | WORD_W | Last complete received byte |
| rx_valid_o | output | 1 | One-cycle strobe on a new received byte |
| rx_ferr_o | output | 1 | Sticky framing error |
| tx_sd_o | output | 1 | Serial transmit data |
| tx_oe_o | output | 1 | Transmit output enable for the pad driver |
| pwr_save_o | output | 1 | Bit clock stopped, power-save request |

## Verification
The bench uses the default parameters: 8-bit words, a two-stage synchronizer and a 16-bit stall counter, with the stall limit set to 40 cycles. At that limit a stopped clock is detected within a few dozen cycles. Normal gaps between frames stay safely under the limit. Bit-clock phases of 3 to 9 system cycles, both even and uneven, check that the block does not depend on the rate ratio. With the short limit, the bench can also stop the clock in the middle of a frame, restart it without a sync and then run a clean frame, all in one short run.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // positions of the oversampled pins inside the synchronizer vector
  localparam int unsigned PIN_BCLK  = 0;
  localparam int unsigned PIN_RSYNC = 1;
  localparam int unsigned PIN_XSYNC = 2;
  localparam int unsigned PIN_RDATA = 3;
  localparam int unsigned PIN_COUNT = 4;

  typedef enum logic [1:0] {
    RX_IDLE     = 2'd0,
    RX_ASSEMBLE = 2'd1,
    RX_DONE     = 2'd2
  } rx_state_e;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;
endpackage

// File: rtl/pcm_in_sync.sv
module pcm_in_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pcm_rx_deser.sv
module pcm_rx_deser
  import pcm_port_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_rise_i,
  input  logic              bit_fall_i,
  input  logic              bit_i,
  input  logic              pwr_save_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o,
  output logic              ferr_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  rx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] shift_q, shift_d;
  logic [WORD_W-1:0] word_q;
  logic              word_en;
  logic              valid_q, valid_d;
  logic              ferr_q, ferr_d;

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shift_d = shift_q;
    word_en = 1'b0;
    valid_d = 1'b0;
    ferr_d  = ferr_q;
    if (pwr_save_i) begin
      state_d = RX_IDLE;
      cnt_d   = '0;
    end else if (sync_rise_i) begin
      if (state_q == RX_ASSEMBLE && cnt_q != '0) begin
        ferr_d = 1'b1;
      end
      state_d = RX_ASSEMBLE;
      cnt_d   = '0;
    end else if (bit_fall_i && state_q == RX_ASSEMBLE) begin
      shift_d = {shift_q[WORD_W-2:0], bit_i};
      if (cnt_q == LAST_BIT) begin
        word_en = 1'b1;
        valid_d = 1'b1;
        state_d = RX_DONE;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      valid_q <= valid_d;
      ferr_q  <= ferr_d;
      if (word_en) begin
        word_q <= shift_d;
      end
    end
  end

  assign word_o  = word_q;
  assign valid_o = valid_q;
  assign ferr_o  = ferr_q;

  // R2
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  // R1
  valid_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_q) |-> $past(bit_fall_i));

  // R3
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_DONE && !sync_rise_i) |=> ($stable(word_q) && !valid_q));

  // R4
  ferr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_q |=> ferr_q);
endmodule

// File: rtl/pcm_tx_ser.sv
module pcm_tx_ser
  import pcm_port_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_rise_i,
  input  logic              bit_rise_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              pwr_save_i,
  output logic              sd_o,
  output logic              oe_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] ALL_SENT = CNT_W'(WORD_W);

  tx_state_e         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] shift_q, shift_d;
  logic              sd_q, sd_d;
  logic              oe_q, oe_d;

  // next state
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shift_d = shift_q;
    sd_d    = sd_q;
    oe_d    = oe_q;
    if (pwr_save_i) begin
      state_d = TX_IDLE;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (sync_rise_i) begin
      state_d = TX_SEND;
      shift_d = word_i;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else if (bit_rise_i && state_q == TX_SEND) begin
      if (cnt_q != ALL_SENT) begin
        sd_d    = shift_q[WORD_W-1];
        shift_d = {shift_q[WORD_W-2:0], 1'b0};
        oe_d    = 1'b1;
        cnt_d   = cnt_q + CNT_W'(1);
      end else begin
        oe_d    = 1'b0;
        state_d = TX_IDLE;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      shift_q <= '0;
      sd_q    <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      sd_q    <= sd_d;
      oe_q    <= oe_d;
    end
  end

  assign sd_o = sd_q;
  assign oe_o = oe_q;

  // R5
  oe_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_q) |-> $past(bit_rise_i));

  // R5
  sd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q && !bit_rise_i) |=> $stable(sd_q));

  // R7
  oe_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_save_i |=> !oe_q);
endmodule

// File: rtl/pcm_clk_watch.sv
module pcm_clk_watch #(
  parameter int unsigned STALL_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               edge_i,
  input  logic [STALL_W-1:0] limit_i,
  output logic               save_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [STALL_W-1:0] idle_q, idle_d;

  // next state: count quiet cycles, saturating at the limit
  always_comb begin
    idle_d = idle_q;
    if (edge_i) begin
      idle_d = '0;
    end else if (idle_q < limit_i) begin
      idle_d = idle_q + STALL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
    end else begin
      idle_q <= idle_d;
    end
  end

  assign save_o = (idle_q >= limit_i);

  // R6
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_i && limit_i != '0) |=> !save_o);

  // R6
  save_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (save_o && !edge_i && $stable(limit_i)) |=> save_o);
endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port
  import pcm_port_pkg::*;
#(
  parameter int unsigned WORD_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned STALL_W     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bclk_i,
  input  logic               rx_sync_i,
  input  logic               rx_sd_i,
  input  logic               tx_sync_i,
  input  logic [WORD_W-1:0]  tx_word_i,
  input  logic [STALL_W-1:0] stop_limit_i,
  output logic [WORD_W-1:0]  rx_word_o,
  output logic               rx_valid_o,
  output logic               rx_ferr_o,
  output logic               tx_sd_o,
  output logic               tx_oe_o,
  output logic               pwr_save_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned EDGE_PINS = PIN_XSYNC + 1;

  // reset: asserted at once, released through two flops
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [PIN_COUNT-1:0] pins_raw, pins_sync;
  assign pins_raw[PIN_BCLK]  = bclk_i;
  assign pins_raw[PIN_RSYNC] = rx_sync_i;
  assign pins_raw[PIN_XSYNC] = tx_sync_i;
  assign pins_raw[PIN_RDATA] = rx_sd_i;

  pcm_in_sync #(
    .WIDTH  (PIN_COUNT),
    .STAGES (SYNC_STAGES)
  ) u_in_sync (
    .clk   (clk),
    .rst_n (rst_sync_q),
    .din   (pins_raw),
    .dout  (pins_sync)
  );

  // one-cycle edge pulses on the synchronized clock and sync pins
  logic [EDGE_PINS-1:0] prev_q;
  logic [EDGE_PINS-1:0] rise_ev, fall_ev;

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      prev_q <= '0;
    end else begin
      prev_q <= pins_sync[EDGE_PINS-1:0];
    end
  end

  for (genvar p = 0; p < EDGE_PINS; p++) begin : g_edge
    assign rise_ev[p] =  pins_sync[p] & ~prev_q[p];
    assign fall_ev[p] = ~pins_sync[p] &  prev_q[p];
  end

  logic bclk_any_edge;
  logic save;
  assign bclk_any_edge = rise_ev[PIN_BCLK] | fall_ev[PIN_BCLK];

  pcm_clk_watch #(
    .STALL_W (STALL_W)
  ) u_clk_watch (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .edge_i  (bclk_any_edge),
    .limit_i (stop_limit_i),
    .save_o  (save)
  );

  pcm_rx_deser #(
    .WORD_W (WORD_W)
  ) u_rx (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .sync_rise_i (rise_ev[PIN_RSYNC]),
    .bit_fall_i  (fall_ev[PIN_BCLK]),
    .bit_i       (pins_sync[PIN_RDATA]),
    .pwr_save_i  (save),
    .word_o      (rx_word_o),
    .valid_o     (rx_valid_o),
    .ferr_o      (rx_ferr_o)
  );

  pcm_tx_ser #(
    .WORD_W (WORD_W)
  ) u_tx (
    .clk         (clk),
    .rst_n       (rst_sync_q),
    .sync_rise_i (rise_ev[PIN_XSYNC]),
    .bit_rise_i  (rise_ev[PIN_BCLK]),
    .word_i      (tx_word_i),
    .pwr_save_i  (save),
    .sd_o        (tx_sd_o),
    .oe_o        (tx_oe_o)
  );

  assign pwr_save_o = save;

  // R7
  save_rx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    pwr_save_o |=> !rx_valid_o);

  // R9
  reset_outputs_chk: assert property (@(posedge clk)
    !rst_sync_q |-> (!rx_valid_o && !tx_oe_o && !rx_ferr_o));
endmodule

// File: tb/pcm_voice_port_bench.sv
module pcm_voice_port_bench;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int LIMIT = 40;

  logic        clk;
  logic        rst_n;
  logic        bclk, rx_sync, rx_sd, tx_sync;
  logic [7:0]  tx_word;
  logic [15:0] stop_limit;
  logic [7:0]  rx_word;
  logic        rx_valid, rx_ferr, tx_sd, tx_oe, pwr_save;

  int errors = 0;
  int checks = 0;
  int vcount = 0;
  bit cmp_en = 0;
  logic [7:0] tx_got;
  int tx_cnt;

  pcm_voice_port u_pcm_voice_port (
    .clk          (clk),
    .rst_n        (rst_n),
    .bclk_i       (bclk),
    .rx_sync_i    (rx_sync),
    .rx_sd_i      (rx_sd),
    .tx_sync_i    (tx_sync),
    .tx_word_i    (tx_word),
    .stop_limit_i (stop_limit),
    .rx_word_o    (rx_word),
    .rx_valid_o   (rx_valid),
    .rx_ferr_o    (rx_ferr),
    .tx_sd_o      (tx_sd),
    .tx_oe_o      (tx_oe),
    .pwr_save_o   (pwr_save)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [3:0] m_s0, m_s1, m_pv;   // {data, xsync, rsync, bclk}
  bit         m_r0, m_r1;
  int         m_stall, m_rcnt, m_tcnt;
  bit         m_armed, m_valid, m_ferr, m_act, m_sd, m_oe;
  logic [7:0] m_sh, m_word, m_txw;

  task automatic m_clear();
    m_s0 = 0; m_s1 = 0; m_pv = 0;
    m_stall = 0; m_rcnt = 0; m_tcnt = 0;
    m_armed = 0; m_valid = 0; m_ferr = 0; m_act = 0; m_sd = 0; m_oe = 0;
    m_sh = 0; m_word = 0; m_txw = 0;
  endtask

  task automatic m_step();
    logic [3:0] ri, fa;
    bit ps;
    ri = m_s1 & ~m_pv;
    fa = ~m_s1 & m_pv;
    ps = (m_stall >= int'(stop_limit));
    if (ri[0] || fa[0]) m_stall = 0;
    else if (m_stall < int'(stop_limit)) m_stall++;
    m_valid = 0;
    if (ps) begin
      m_armed = 0; m_rcnt = 0;
    end else if (ri[1]) begin
      if (m_armed && m_rcnt > 0 && m_rcnt < 8) m_ferr = 1;
      m_armed = 1; m_rcnt = 0;
    end else if (fa[0] && m_armed && m_rcnt < 8) begin
      m_sh = {m_sh[6:0], m_s1[3]};
      m_rcnt++;
      if (m_rcnt == 8) begin m_word = m_sh; m_valid = 1; end
    end
    if (ps) begin
      m_act = 0; m_tcnt = 0; m_oe = 0;
    end else if (ri[2]) begin
      m_act = 1; m_txw = tx_word; m_tcnt = 0; m_oe = 0;
    end else if (ri[0] && m_act) begin
      if (m_tcnt < 8) begin m_sd = m_txw[7-m_tcnt]; m_oe = 1; m_tcnt++; end
      else begin m_oe = 0; m_act = 0; end
    end
    m_pv = m_s1;
    m_s1 = m_s0;
    m_s0 = {rx_sd, tx_sync, rx_sync, bclk};
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_clear(); m_r0 = 0; m_r1 = 0;
    end else begin
      if (!m_r1) m_clear();
      else m_step();
      m_r1 = m_r0;
      m_r0 = 1;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rx_valid === 1'b1) vcount++;
    if (cmp_en) begin
      check(rx_valid === m_valid, "R2", "rx_valid", rx_valid, m_valid);
      check(rx_word === m_word, "R1", "rx_word", rx_word, m_word);
      check(rx_ferr === m_ferr, "R4", "rx_ferr", rx_ferr, m_ferr);
      check(tx_oe === m_oe, "R5", "tx_oe", tx_oe, m_oe);
      if (m_oe) check(tx_sd === m_sd, "R5", "tx_sd", tx_sd, m_sd);
      check(pwr_save === (m_stall >= int'(stop_limit)), "R6", "pwr_save",
            pwr_save, (m_stall >= int'(stop_limit)));
    end
  end

  // ---------------- stimulus ----------------
  task automatic frame(input logic [7:0] rw, input logic [7:0] tw, input int nclk,
                       input int hi, input int lo, input bit rs_en, input bit xs_en);
    tx_word = tw;
    tx_got  = 0;
    tx_cnt  = 0;
    for (int i = 0; i < nclk; i++) begin
      @(negedge clk);
      bclk    = 1'b1;
      rx_sd   = (i < 8) ? rw[7-i] : 1'($urandom);
      rx_sync = rs_en && (i == 0);
      tx_sync = xs_en && (i == 0);
      repeat (hi) @(negedge clk);
      if (tx_oe === 1'b1) begin
        tx_got = {tx_got[6:0], tx_sd};
        tx_cnt++;
      end
      bclk = 1'b0;
      repeat (lo - 1) @(negedge clk);
    end
    @(negedge clk);
    rx_sync = 1'b0;
    tx_sync = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int v0;
    rst_n = 1'b0; bclk = 0; rx_sync = 0; rx_sd = 0; tx_sync = 0;
    tx_word = 0; stop_limit = 16'(LIMIT);
    repeat (5) @(negedge clk);
    // R9 reset state
    check(rx_word === 8'h00, "R9", "rx_word in reset", rx_word, 0);
    check(rx_valid === 1'b0, "R9", "rx_valid in reset", rx_valid, 0);
    check(rx_ferr === 1'b0, "R9", "rx_ferr in reset", rx_ferr, 0);
    check(tx_oe === 1'b0, "R9", "tx_oe in reset", tx_oe, 0);
    check(pwr_save === 1'b0, "R9", "pwr_save in reset", pwr_save, 0);
    rst_n = 1'b1;
    cmp_en = 1;

    // R6: idle bit clock after reset raises power save, edges clear it
    repeat (LIMIT + 10) @(negedge clk);
    check(pwr_save === 1'b1, "R6", "pwr_save after stall", pwr_save, 1);
    frame(8'h00, 8'h00, 3, 8, 8, 0, 0);
    check(pwr_save === 1'b0, "R6", "pwr_save after restart", pwr_save, 0);

    // R1 R2 R5 basic frame
    v0 = vcount;
    frame(8'hA5, 8'h3C, 10, 8, 8, 1, 1);
    check(rx_word === 8'hA5, "R1", "word A", rx_word, 8'hA5);
    check(vcount == v0 + 1, "R2", "valid pulses A", vcount - v0, 1);
    check(tx_got === 8'h3C, "R5", "tx bits A", tx_got, 8'h3C);
    check(tx_cnt == 8, "R5", "tx slots A", tx_cnt, 8);

    // R3 extra clocks, uneven phases (R8)
    v0 = vcount;
    frame(8'h5A, 8'hC3, 13, 7, 9, 1, 1);
    check(rx_word === 8'h5A, "R3", "word B after extra clocks", rx_word, 8'h5A);
    check(vcount == v0 + 1, "R3", "valid pulses B", vcount - v0, 1);
    check(tx_cnt == 8, "R5", "tx slots B", tx_cnt, 8);

    // R8 short phases
    frame(8'h01, 8'h80, 10, 3, 3, 1, 1);
    check(rx_word === 8'h01, "R8", "word C fast clock", rx_word, 8'h01);
    check(tx_got === 8'h80, "R8", "tx bits C fast clock", tx_got, 8'h80);
    check(rx_ferr === 1'b0, "R4", "no framing error yet", rx_ferr, 0);

    // R4 early sync
    v0 = vcount;
    frame(8'hFF, 8'h55, 4, 8, 8, 1, 1);
    frame(8'h12, 8'h81, 10, 8, 8, 1, 1);
    check(rx_ferr === 1'b1, "R4", "ferr after early sync", rx_ferr, 1);
    check(rx_word === 8'h12, "R4", "word after restart", rx_word, 8'h12);
    check(vcount == v0 + 1, "R4", "no valid for partial", vcount - v0, 1);
    check(tx_got === 8'h81, "R5", "tx bits after reload", tx_got, 8'h81);
    frame(8'h6E, 8'h18, 10, 8, 8, 1, 1);
    check(rx_ferr === 1'b1, "R4", "ferr sticky", rx_ferr, 1);
    check(rx_word === 8'h6E, "R1", "word D", rx_word, 8'h6E);

    // R7 clock stops mid-frame
    frame(8'hF0, 8'hAA, 4, 8, 8, 1, 1);
    repeat (LIMIT + 20) @(negedge clk);
    check(pwr_save === 1'b1, "R6", "pwr_save mid-frame stall", pwr_save, 1);
    check(tx_oe === 1'b0, "R7", "tx_oe in power save", tx_oe, 0);
    v0 = vcount;
    frame(8'hF0, 8'hAA, 8, 8, 8, 0, 0);
    check(vcount == v0, "R7", "no valid without sync", vcount - v0, 0);
    check(tx_cnt == 0, "R7", "no tx slots without sync", tx_cnt, 0);
    check(rx_word === 8'h6E, "R7", "word kept after abandoned frame", rx_word, 8'h6E);
    frame(8'h77, 8'h99, 10, 5, 6, 1, 1);
    check(rx_word === 8'h77, "R1", "word after wake", rx_word, 8'h77);
    check(tx_got === 8'h99, "R5", "tx bits after wake", tx_got, 8'h99);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule